// File: doc/BRIEF.md
# Banked Gamma Lookup Pixel Stage

This block applies a programmable per-channel transfer curve to a stream of RGB pixels. Each pixel carries three 12-bit components (red in bits 35:24, green in 23:12, blue in 11:0). The upper 10 bits of each component select one of 1024 table entries for that channel. The corrected component is taken from that entry. Pixels enter and leave with valid/ready handshakes and cross a fixed two-stage pipeline.

Software reaches the block through a write-only register port: an enable word, a control word, a frame size, a bank/format word, and two table windows. The table is loaded one 256-entry bank at a time through a window. Entries arrive either as three 10-bit fields packed in one word, or as 12-bit fields spread over two windows. With differential storage, odd entries hold an increment over the even entry before them. The block rebuilds the true value during each lookup.

Frame position is counted from the programmed size. The output marks the last pixel of each frame. The enable, control, size and format settings are latched at each frame start, so a change made part-way through a frame first applies to the next frame.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, out_valid and out_eof are low and in_ready is high.
- R2: Writing 0 to bit 0 of the enable word (offset 0x000) makes pixels leave unchanged. Reset leaves it at 0.
- R3: In the control word (offset 0x020), bit 0 set forces pass-through and bit 1 clear forces pass-through. A lookup happens only when enable is 1, bit 0 is 0 and bit 1 is 1.
- R4: When bank-word (offset 0x100) bit 2 is 0, the format is 10-bit. A write at 0x700+4*i loads entry bank*256+i with red from bits 29:20, green from 19:10 and blue from 9:0. The output component is the entry value shifted left by 2. The entry index is component bits 11:2.
- R5: When bank-word bit 2 is 1, the format is 12-bit. A write at 0x700+4*i loads red from bits 11:0 and green from bits 23:12. A write at 0xB00+4*i loads blue from bits 11:0. The output component is the 12-bit entry.
- R6: Bank-word bits 1:0 select which 256-entry bank the windows address. Entries in every bank are reachable by lookup.
- R7: An even index returns its stored value. An odd index returns the sum of the stored value and the preceding even entry, modulo 2^10 in 10-bit format and 2^12 in 12-bit format.
- R8: The size word (offset 0x030) holds the row width in bits 28:16 and the row count in bits 12:0. out_eof is high with the pixel that is last in its row and last in the frame. A size of 0 counts as 1.
- R9: Enable, control, size and format changes written after a frame's first pixel has been accepted take effect from the next frame's first pixel.
- R10: With out_ready high, a pixel accepted in cycle c is presented in cycle c+2. Under backpressure the output holds, and no pixel is dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_pix | input | 36 | Input pixel, R/G/B 12 bits each |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_pix | output | 36 | Corrected pixel |
| out_eof | output | 1 | Output pixel is the last of its frame |

## Verification
A wrong table write or a faulty odd-entry rebuild shows up as a wrong component. It appears two cycles after the first pixel that indexes the affected entry, so the bench's pixel patterns mix even and odd indices across all banks. A corrupted frame counter or shadow copy shows up at the next frame boundary: out_eof goes high on the wrong pixel, or a frame changes between lookup and pass-through in the middle. A pipeline hold fault loses or repeats a pixel only while out_ready is low. It is caught the first time the next expected pixel fails to match in order.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int PIX_W    = 12;
    localparam int CH_N     = 3;
    localparam int IDX_W    = 10;
    localparam int BANK_W   = 2;
    localparam int NARROW_W = 10;
    localparam int SIZE_W   = 13;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 32;
    localparam int ENT_W    = IDX_W - BANK_W;
    localparam int BANK_ENTRIES = 1 << ENT_W;

    localparam logic [ADDR_W-1:0] OFF_ENABLE   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CONTROL  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_SIZE     = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_BANK     = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_WIN_MAIN = 12'h700;
    localparam logic [ADDR_W-1:0] OFF_WIN_BLUE = 12'hB00;

    typedef logic [CH_N-1:0][PIX_W-1:0] pix_t;

    typedef struct packed {
        logic              enable;
        logic              relay;
        logic              lut_on;
        logic              wide;
        logic [SIZE_W-1:0] hsize;
        logic [SIZE_W-1:0] vsize;
    } gcfg_t;
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output gcfg_t             pend_cfg,
    output logic              we_main,
    output logic              we_blue,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_wide
);
    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(BANK_ENTRIES * 4);

    typedef struct packed {
        gcfg_t             cfg;
        logic [BANK_W-1:0] bank;
    } regs_t;

    regs_t r_d, r_q;
    logic [ADDR_W-1:0] off_main, off_blue;
    logic hit_main, hit_blue;

    always_comb begin
        off_main = reg_addr - OFF_WIN_MAIN;
        off_blue = reg_addr - OFF_WIN_BLUE;
        hit_main = (reg_addr >= OFF_WIN_MAIN) && (off_main < WIN_SPAN) && (reg_addr[1:0] == 2'b00);
        hit_blue = (reg_addr >= OFF_WIN_BLUE) && (off_blue < WIN_SPAN) && (reg_addr[1:0] == 2'b00);

        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                OFF_ENABLE:  r_d.cfg.enable = reg_wdata[0];
                OFF_CONTROL: begin
                    r_d.cfg.relay  = reg_wdata[0];
                    r_d.cfg.lut_on = reg_wdata[1];
                end
                OFF_SIZE: begin
                    r_d.cfg.hsize = reg_wdata[16 +: SIZE_W];
                    r_d.cfg.vsize = reg_wdata[0 +: SIZE_W];
                end
                OFF_BANK: begin
                    r_d.bank     = reg_wdata[BANK_W-1:0];
                    r_d.cfg.wide = reg_wdata[BANK_W];
                end
                default: ;
            endcase
        end

        we_main = reg_wr && hit_main;
        we_blue = reg_wr && hit_blue && r_q.cfg.wide;
        wr_idx  = {r_q.bank, hit_blue ? off_blue[2 +: ENT_W] : off_main[2 +: ENT_W]};
        wr_data = reg_wdata;
        wr_wide = r_q.cfg.wide;
        pend_cfg = r_q.cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_BLUE_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        we_blue |-> (wr_wide && !we_main)) else $error("blue window write outside 12-bit format"); // R5
endmodule

// File: rtl/gamma_frame_ctl.sv
module gamma_frame_ctl
    import gamma_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  accept,
    input  gcfg_t pend_cfg,
    output logic  pix_bypass,
    output logic  pix_wide,
    output logic  pix_last
);
    typedef struct packed {
        logic [SIZE_W-1:0] x;
        logic [SIZE_W-1:0] y;
        gcfg_t             act;
    } fc_t;

    fc_t f_d, f_q;
    gcfg_t eff;
    logic at_start, col_last, row_last;
    logic [SIZE_W:0] x_nxt, y_nxt;

    always_comb begin
        at_start = (f_q.x == '0) && (f_q.y == '0);
        eff      = at_start ? pend_cfg : f_q.act;
        x_nxt    = {1'b0, f_q.x} + 1'b1;
        y_nxt    = {1'b0, f_q.y} + 1'b1;
        col_last = x_nxt >= {1'b0, eff.hsize};
        row_last = y_nxt >= {1'b0, eff.vsize};

        pix_last   = col_last && row_last;
        pix_bypass = !(eff.enable && !eff.relay && eff.lut_on);
        pix_wide   = eff.wide;

        f_d = f_q;
        if (at_start) f_d.act = pend_cfg;
        if (accept) begin
            if (col_last) begin
                f_d.x = '0;
                f_d.y = row_last ? '0 : y_nxt[SIZE_W-1:0];
            end else begin
                f_d.x = x_nxt[SIZE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_start && f_q.act.hsize != '0) |-> (f_q.x < f_q.act.hsize)) else $error("column past row width"); // R8
    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_start && f_q.act.vsize != '0) |-> (f_q.y < f_q.act.vsize)) else $error("row past frame height"); // R8
endmodule

// File: rtl/gamma_table.sv
module gamma_table
    import gamma_pkg::*;
#(
    parameter bit DIFF_EN = 1'b1
) (
    input  logic              clk,
    input  logic              we_main,
    input  logic              we_blue,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_wide,
    input  pix_t              look_pix,
    input  logic              look_wide,
    output pix_t              look_val
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int PAD_W   = PIX_W - NARROW_W;

    pix_t tbl [ENTRIES];

    logic unused_hi;
    assign unused_hi = ^wr_data[WORD_W-1:3*NARROW_W];

    always_ff @(posedge clk) begin
        if (we_main) begin
            if (wr_wide) begin
                tbl[wr_idx][2] <= wr_data[PIX_W-1:0];
                tbl[wr_idx][1] <= wr_data[2*PIX_W-1:PIX_W];
            end else begin
                tbl[wr_idx][2] <= PIX_W'(wr_data[3*NARROW_W-1:2*NARROW_W]);
                tbl[wr_idx][1] <= PIX_W'(wr_data[2*NARROW_W-1:NARROW_W]);
                tbl[wr_idx][0] <= PIX_W'(wr_data[NARROW_W-1:0]);
            end
        end
        if (we_blue) tbl[wr_idx][0] <= wr_data[PIX_W-1:0];
    end

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] even_idx;
        logic [PIX_W-1:0] raw, base, sum;
        logic unused_lo;

        assign idx       = look_pix[ch][PIX_W-1 -: IDX_W];
        assign even_idx  = {idx[IDX_W-1:1], 1'b0};
        assign unused_lo = ^look_pix[ch][PIX_W-IDX_W-1:0];
        assign raw       = tbl[idx][ch];
        assign base      = tbl[even_idx][ch];
        assign sum       = (DIFF_EN && idx[0]) ? (base + raw) : raw;
        assign look_val[ch] = look_wide ? sum : {sum[NARROW_W-1:0], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_pkg::*;
#(
    parameter bit DIFF_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [CH_N*PIX_W-1:0]  in_pix,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [CH_N*PIX_W-1:0]  out_pix,
    output logic                   out_eof
);
    typedef struct packed {
        logic v;
        pix_t pix;
        logic bypass;
        logic wide;
        logic eof;
    } s1_t;

    typedef struct packed {
        logic v;
        pix_t pix;
        logic eof;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;

    pipe_t p_d, p_q;

    gcfg_t             pend_cfg;
    logic              we_main, we_blue, wr_wide;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic              fc_bypass, fc_wide, fc_last;
    logic              accept, s1_free, s2_free;
    pix_t              lut_val;

    gamma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pend_cfg(pend_cfg), .we_main(we_main),
        .we_blue(we_blue), .wr_idx(wr_idx), .wr_data(wr_data), .wr_wide(wr_wide)
    );

    gamma_frame_ctl u_frame (
        .clk(clk), .rst_n(rst_n), .accept(accept), .pend_cfg(pend_cfg),
        .pix_bypass(fc_bypass), .pix_wide(fc_wide), .pix_last(fc_last)
    );

    gamma_table #(.DIFF_EN(DIFF_EN)) u_table (
        .clk(clk), .we_main(we_main), .we_blue(we_blue), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_wide(wr_wide), .look_pix(p_q.s1.pix),
        .look_wide(p_q.s1.wide), .look_val(lut_val)
    );

    always_comb begin
        s2_free  = !p_q.s2.v || out_ready;
        s1_free  = !p_q.s1.v || s2_free;
        in_ready = s1_free;
        accept   = in_valid && s1_free;

        p_d = p_q;
        if (s2_free) begin
            p_d.s2.v = p_q.s1.v;
            if (p_q.s1.v) begin
                p_d.s2.pix = p_q.s1.bypass ? p_q.s1.pix : lut_val;
                p_d.s2.eof = p_q.s1.eof;
            end
        end
        if (s1_free) begin
            p_d.s1.v = in_valid;
            if (in_valid) begin
                p_d.s1.pix    = pix_t'(in_pix);
                p_d.s1.bypass = fc_bypass;
                p_d.s1.wide   = fc_wide;
                p_d.s1.eof    = fc_last;
            end
        end

        out_valid = p_q.s2.v;
        out_pix   = p_q.s2.pix;
        out_eof   = p_q.s2.v && p_q.s2.eof;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_eof))) else $error("output changed while stalled"); // R10
    AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.s1.v && !s2_free) |=> (p_q.s1.v && $stable(p_q.s1))) else $error("middle stage lost a pixel"); // R10
    AST_READY_WHEN_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready) else $error("input blocked while output drains"); // R10
    AST_ACCEPT_REACHES_MID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> p_q.s1.v) else $error("accepted pixel missing from middle stage"); // R10
endmodule

// File: tb/sim_gamma_lut_stage.sv
module sim_gamma_lut_stage;
    import gamma_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic in_valid = 1'b0, in_ready;
    logic [35:0] in_pix = '0;
    logic out_valid, out_ready = 1'b1, out_eof;
    logic [35:0] out_pix;

    gamma_lut_stage u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix), .out_eof(out_eof)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int m_tbl [0:1023][0:2];
    bit m_en, m_relay, m_lut, m_wide;
    int m_h, m_v, m_bank;
    bit a_en, a_relay, a_lut, a_wide;
    int a_h, a_v;
    int ex = 0, ey = 0;
    logic [35:0] exp_q[$];
    bit eof_q[$];
    string tag_q[$];
    int due_q[$];
    bit lat_check = 1'b0;
    string phase = "R2";

    task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [35:0] expect_pix(logic [35:0] p, bit wide);
        logic [35:0] r;
        r = '0;
        for (int ch = 0; ch < 3; ch++) begin
            int idx, v;
            idx = int'(p[ch*12 +: 12]) >> 2;
            v = m_tbl[idx][ch];
            if (idx % 2 == 1) v = v + m_tbl[idx-1][ch];
            if (wide) r[ch*12 +: 12] = 12'(v & 4095);
            else      r[ch*12 +: 12] = 12'((v & 1023) << 2);
        end
        return r;
    endfunction

    // reference model, sampled mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (rst_n) begin
            if (lat_check && due_q.size() > 0 && due_q[0] == cyc && !out_valid)
                chk(1'b0, "R10 latency", 36'(out_valid), 36'd1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R10 extra output", out_pix, '0);
                else begin
                    logic [35:0] e; bit eo; string t; int d;
                    e = exp_q.pop_front(); eo = eof_q.pop_front();
                    t = tag_q.pop_front(); d = due_q.pop_front();
                    chk(out_pix === e, t, out_pix, e);
                    chk(out_eof === eo, "R8 eof", 36'(out_eof), 36'(eo));
                    if (lat_check) chk(cyc == d, "R10 latency", 36'(cyc), 36'(d));
                end
            end
            if (in_valid && in_ready) begin
                bit at_s, byp, cl, rl;
                at_s = (ex == 0) && (ey == 0);
                if (at_s) begin
                    a_en = m_en; a_relay = m_relay; a_lut = m_lut; a_wide = m_wide;
                    a_h = (m_h == 0) ? 1 : m_h; a_v = (m_v == 0) ? 1 : m_v;
                end
                byp = !(a_en && !a_relay && a_lut);
                exp_q.push_back(byp ? in_pix : expect_pix(in_pix, a_wide));
                cl = (ex + 1 >= a_h); rl = (ey + 1 >= a_v);
                eof_q.push_back(cl && rl);
                tag_q.push_back(phase);
                due_q.push_back(cyc + 2);
                if (cl) begin ex = 0; ey = rl ? 0 : ey + 1; end
                else ex = ex + 1;
            end
            if (reg_wr) begin
                int a, d;
                a = int'(reg_addr); d = int'(reg_wdata);
                if (a == 'h000) m_en = d[0];
                else if (a == 'h020) begin m_relay = d[0]; m_lut = d[1]; end
                else if (a == 'h030) begin m_h = (d >> 16) & 8191; m_v = d & 8191; end
                else if (a == 'h100) begin m_bank = d & 3; m_wide = d[2]; end
                else if (a >= 'h700 && a < 'hB00 && a % 4 == 0) begin
                    int n;
                    n = m_bank * 256 + (a - 'h700) / 4;
                    if (m_wide) begin
                        m_tbl[n][2] = d & 4095; m_tbl[n][1] = (d >> 12) & 4095;
                    end else begin
                        m_tbl[n][2] = (d >> 20) & 1023; m_tbl[n][1] = (d >> 10) & 1023;
                        m_tbl[n][0] = d & 1023;
                    end
                end else if (a >= 'hB00 && a < 'hF00 && a % 4 == 0 && m_wide) begin
                    m_tbl[m_bank * 256 + (a - 'hB00) / 4][0] = d & 4095;
                end
            end
        end
    end

    // all drivers run at posedge + 2
    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = 32'(d);
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic send(logic [35:0] p);
        in_valid = 1'b1; in_pix = p;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin @(posedge clk); #2; end
        repeat (2) begin @(posedge clk); #2; end
    endtask

    function automatic logic [35:0] pat(int k, int kind);
        int r, g, b;
        r = (k * 397 + 5) & 4095; g = (k * 1231 + 77) & 4095; b = (k * 613 + 901) & 4095;
        if (kind == 1) begin // odd indices only
            r = r | 4; g = g | 4; b = b | 4;
        end else if (kind == 2) begin // high banks
            r = r | 'hC00; g = (g & 'h3FF) | 'h800;
        end
        return {12'(r), 12'(g), 12'(b)};
    endfunction

    task automatic frame(int base, int kind);
        for (int k = 0; k < 8; k++) send(pat(base + k, kind));
    endtask

    bit done_bp = 1'b0;
    int lf = 12345;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", 36'(out_valid), 36'd0);
        chk(out_eof == 1'b0, "R1 out_eof", 36'(out_eof), 36'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 36'(in_ready), 36'd1);
        @(posedge clk); #2;

        lat_check = 1'b1;
        phase = "R2 disabled pass-through";
        for (int k = 0; k < 3; k++) send(pat(k, 0));
        drain();

        wr('h030, (4 << 16) | 2);
        for (int b = 0; b < 4; b++) begin
            wr('h100, b);
            for (int i = 0; i < 256; i++) begin
                int n;
                n = b * 256 + i;
                wr('h700 + 4 * i, (((n * 5 + 3) & 1023) << 20) | (((1023 - n * 3) & 1023) << 10) | ((n * 11) & 1023));
            end
        end
        wr('h020, 2);
        wr('h000, 1);
        phase = "R4 10-bit lookup"; frame(10, 0); drain();
        phase = "R7 odd rebuild 10-bit"; frame(30, 1); drain();
        wr('h020, 3);
        phase = "R3 relay pass-through"; frame(50, 0); drain();
        wr('h020, 0);
        phase = "R3 table off pass-through"; frame(60, 0); drain();

        wr('h020, 2);
        phase = "R9 frame keeps lookup";
        for (int k = 0; k < 3; k++) send(pat(70 + k, 0));
        wr('h020, 3);
        for (int k = 3; k < 8; k++) send(pat(70 + k, 0));
        phase = "R9 next frame relays"; frame(80, 0); drain();
        wr('h020, 2);

        for (int b = 0; b < 4; b++) begin
            wr('h100, 4 | b);
            for (int i = 0; i < 256; i++) begin
                int n;
                n = b * 256 + i;
                wr('h700 + 4 * i, (((4095 - n * 2) & 4095) << 12) | ((n * 13 + 7) & 4095));
                wr('hB00 + 4 * i, (n * 29 + 100) & 4095);
            end
        end
        phase = "R5 12-bit lookup"; frame(90, 0); drain();
        phase = "R7 odd rebuild 12-bit"; frame(100, 1); drain();
        phase = "R6 upper banks"; frame(110, 2); drain();

        wr('h030, (3 << 16) | 1);
        phase = "R8 three-pixel frames"; frame(120, 0); drain();
        wr('h030, (4 << 16) | 2);
        drain();

        lat_check = 1'b0;
        phase = "R10 backpressure";
        fork
            begin
                for (int k = 0; k < 24; k++) send(pat(200 + k, k % 3));
                done_bp = 1'b1;
            end
            begin
                while (!done_bp) begin
                    @(posedge clk); #2;
                    lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
                    out_ready = ((lf >> 16) % 3) != 0;
                end
            end
        join
        out_ready = 1'b1;
        drain();
        chk(exp_q.size() == 0, "R10 no loss", 36'(exp_q.size()), 36'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule